// File: doc/BRIEF.md
# Two-Stage Clock Ratio Planner

This block works out how to split a clock division between a coarse pre-divider and a fine post-divider. It takes the rate of the selected source clock, the rate the consumer wants and the index of that source. It returns the two divider fields, each encoded as ratio minus one, and the output rate those settings actually give. A single iterative restoring divider does all the arithmetic. It is reused for the total ratio, the band split and the two steps of the achieved-rate calculation. A new job is accepted only while the block is idle.

Only one source index sends the ratio through the pre-divider. For that source, ratios above the post-divider range are spread over both stages using fixed bands. Every other source uses the post-divider alone. The requested rate is clamped to the source rate first, because a divider cannot raise a frequency.

Top module: `ratio_split_planner`

## Requirements
- R1: When the parent rate is nonzero and the target rate is above it, the target is replaced by the parent rate before any other step, which gives a total ratio of 1.
- R2: The total ratio is ceil(parent / target), using the clamped target. A result of 0, which happens when the parent rate is 0, is raised to 1.
- R3: When the source index is not 3, or the total ratio is 4 or less, the pre-divide ratio is 1 and the post-divide ratio equals the total ratio.
- R4: When the source index is 3 and the total ratio is 5 to 31, the pre-divide ratio equals the total ratio and the post-divide ratio is 1.
- R5: When the source index is 3, the post-divide ratio is 2 for total ratios 32 to 63, 3 for 64 to 95 and 4 for 96 and above. The pre-divide ratio is then ceil(total / post).
- R6: `pre_field_o` (5 bits) carries the pre-divide ratio minus 1. `post_field_o` (2 bits) carries the post-divide ratio minus 1.
- R7: `rate_o` = floor(floor(parent / pre) / post).
- R8: The pre-divide ratio saturates at 32 and the post-divide ratio saturates at 4.
- R9: A target rate of 0 is treated as a total ratio of 2^32-1, so no division by zero occurs.
- R10: `busy_o` is high from the cycle after an accepted `start_i` until `done_o`. `done_o` is a one-cycle pulse with all three outputs valid, and `busy_o` is low in that same cycle. A `start_i` seen while busy is ignored. The outputs hold until the next `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a calculation (accepted when idle) |
| parent_i | input | 32 | Source clock rate |
| target_i | input | 32 | Requested output rate |
| src_i | input | 2 | Source index; 3 enables the pre-divider |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result strobe |
| pre_field_o | output | 5 | Pre-divide ratio minus one |
| post_field_o | output | 2 | Post-divide ratio minus one |
| rate_o | output | 32 | Achieved output rate |

## Verification
The bench targets every band edge for source 3 (total ratios 4, 5, 31, 32, 63, 64, 95, 96):
- An off-by-one comparison there moves a ratio into the neighbouring band and gives wrong fields.

The bench also sends a zero target and a zero parent:
- A design that divided by the raw target would hang or report garbage for a zero target.
- A design that skipped the floor of 1 would encode a ratio of zero for a zero parent, which wraps the field to all ones.

The clamp case and the saturation at 32/4 are driven directly:
- A design without saturation would wrap the 5-bit field on large ratios.

Finally, a second start is issued mid-calculation:
- A design that restarted on it would report the second job's result.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RATIO,
    ST_SPLIT,
    ST_PRE,
    ST_ACH1,
    ST_ACH2
  } rsp_state_e;
endpackage

// File: rtl/rsp_seq_div.sv
module rsp_seq_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  always_comb begin
    shifted = {rem_o, quo_o[W-1]};
    trial   = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      quo_o  <= '0;
      rem_o  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        quo_o <= num_i;
        rem_o <= '0;
        den_q <= den_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!trial[W]) begin
          rem_o <= trial[W-1:0];
          quo_o <= {quo_o[W-2:0], 1'b1};
        end else begin
          rem_o <= shifted[W-1:0];
          quo_o <= {quo_o[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R2
  rem_below_den_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rem_o < den_q));
endmodule

// File: rtl/rsp_band_split.sv
module rsp_band_split #(
  parameter int W         = 32,
  parameter int SW        = 2,
  parameter int PRE_MAX   = 32,
  parameter int POST_MAX  = 4,
  parameter int SPLIT_SRC = 3
) (
  input  logic [W-1:0]                     ratio_i,
  input  logic [SW-1:0]                    src_i,
  output logic [$clog2(PRE_MAX+1)-1:0]     pre_o,
  output logic [$clog2(POST_MAX+1)-1:0]    post_o,
  output logic                             need_ceil_o
);
  localparam int PREW  = $clog2(PRE_MAX + 1);
  localparam int POSTW = $clog2(POST_MAX + 1);

  always_comb begin
    pre_o       = PREW'(1);
    post_o      = POSTW'(1);
    need_ceil_o = 1'b0;
    if (src_i != SW'(SPLIT_SRC) || ratio_i <= W'(POST_MAX)) begin
      if (ratio_i > W'(POST_MAX)) post_o = POSTW'(POST_MAX);
      else                        post_o = POSTW'(ratio_i);
    end else if (ratio_i < W'(PRE_MAX)) begin
      pre_o = PREW'(ratio_i);
    end else begin
      need_ceil_o = 1'b1;
      post_o      = POSTW'(POST_MAX);
      for (int k = POST_MAX - 1; k >= 2; k--) begin
        if (ratio_i < W'(k * PRE_MAX)) post_o = POSTW'(k);
      end
    end
  end
endmodule

// File: rtl/ratio_split_planner.sv
module ratio_split_planner #(
  parameter int W         = 32,
  parameter int SW        = 2,
  parameter int PRE_MAX   = 32,
  parameter int POST_MAX  = 4,
  parameter int SPLIT_SRC = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic [W-1:0]                  parent_i,
  input  logic [W-1:0]                  target_i,
  input  logic [SW-1:0]                 src_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [$clog2(PRE_MAX)-1:0]    pre_field_o,
  output logic [$clog2(POST_MAX)-1:0]   post_field_o,
  output logic [W-1:0]                  rate_o
);
  import rsp_pkg::*;

  localparam int PFW   = $clog2(PRE_MAX);
  localparam int QFW   = $clog2(POST_MAX);
  localparam int PREW  = $clog2(PRE_MAX + 1);
  localparam int POSTW = $clog2(POST_MAX + 1);

  rsp_state_e       st_q;
  logic [W-1:0]     par_q, ratio_q;
  logic [SW-1:0]    src_q;
  logic [PREW-1:0]  pre_q;
  logic [POSTW-1:0] post_q;
  logic             dv_go;
  logic [W-1:0]     dv_num, dv_den;
  logic             dv_done;
  logic [W-1:0]     dv_quo, dv_rem;
  logic [W-1:0]     eff_target, ceil_v;
  logic [PREW-1:0]  pre_sat, bs_pre;
  logic [POSTW-1:0] bs_post;
  logic             bs_need;

  rsp_seq_div #(.W(W)) u_div (
    .clk(clk), .rst(rst), .start_i(dv_go), .num_i(dv_num), .den_i(dv_den),
    .done_o(dv_done), .quo_o(dv_quo), .rem_o(dv_rem)
  );

  rsp_band_split #(
    .W(W), .SW(SW), .PRE_MAX(PRE_MAX), .POST_MAX(POST_MAX), .SPLIT_SRC(SPLIT_SRC)
  ) u_band (
    .ratio_i(ratio_q), .src_i(src_q), .pre_o(bs_pre), .post_o(bs_post),
    .need_ceil_o(bs_need)
  );

  always_comb begin
    eff_target = (parent_i != '0 && target_i > parent_i) ? parent_i : target_i;
    ceil_v     = dv_quo + W'(dv_rem != '0);
    pre_sat    = (ceil_v > W'(PRE_MAX)) ? PREW'(PRE_MAX) : PREW'(ceil_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      par_q        <= '0;
      ratio_q      <= '0;
      src_q        <= '0;
      pre_q        <= PREW'(1);
      post_q       <= POSTW'(1);
      dv_go        <= 1'b0;
      dv_num       <= '0;
      dv_den       <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      pre_field_o  <= '0;
      post_field_o <= '0;
      rate_o       <= '0;
    end else begin
      dv_go  <= 1'b0;
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          par_q  <= parent_i;
          src_q  <= src_i;
          busy_o <= 1'b1;
          if (eff_target == '0) begin
            ratio_q <= '1;
            st_q    <= ST_SPLIT;
          end else begin
            dv_go  <= 1'b1;
            dv_num <= parent_i;
            dv_den <= eff_target;
            st_q   <= ST_RATIO;
          end
        end
        ST_RATIO: if (dv_done) begin
          ratio_q <= (ceil_v == '0) ? W'(1) : ceil_v;
          st_q    <= ST_SPLIT;
        end
        ST_SPLIT: begin
          post_q <= bs_post;
          dv_go  <= 1'b1;
          if (bs_need) begin
            dv_num <= ratio_q;
            dv_den <= W'(bs_post);
            st_q   <= ST_PRE;
          end else begin
            pre_q  <= bs_pre;
            dv_num <= par_q;
            dv_den <= W'(bs_pre);
            st_q   <= ST_ACH1;
          end
        end
        ST_PRE: if (dv_done) begin
          pre_q  <= pre_sat;
          dv_go  <= 1'b1;
          dv_num <= par_q;
          dv_den <= W'(pre_sat);
          st_q   <= ST_ACH1;
        end
        ST_ACH1: if (dv_done) begin
          dv_go  <= 1'b1;
          dv_num <= dv_quo;
          dv_den <= W'(post_q);
          st_q   <= ST_ACH2;
        end
        ST_ACH2: if (dv_done) begin
          rate_o       <= dv_quo;
          pre_field_o  <= PFW'(pre_q - PREW'(1));
          post_field_o <= QFW'(post_q - POSTW'(1));
          done_o       <= 1'b1;
          busy_o       <= 1'b0;
          st_q         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(par_q));
  // R8
  ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pre_q >= PREW'(1) && pre_q <= PREW'(PRE_MAX) &&
                post_q >= POSTW'(1) && post_q <= POSTW'(POST_MAX)));
  // R7
  rate_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rate_o <= par_q));
  // R3
  nosplit_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && src_q != SW'(SPLIT_SRC)) |-> (pre_field_o == '0));
endmodule

// File: tb/ratio_split_planner_tb.sv
`timescale 1ns/1ps
module ratio_split_planner_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] parent, target;
  logic [1:0]  src;
  logic        busy, done;
  logic [4:0]  pre_f;
  logic [1:0]  post_f;
  logic [31:0] rate;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  ratio_split_planner u_dut (
    .clk(clk), .rst(rst), .start_i(start), .parent_i(parent), .target_i(target),
    .src_i(src), .busy_o(busy), .done_o(done), .pre_field_o(pre_f),
    .post_field_o(post_f), .rate_o(rate)
  );

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input longint unsigned p, input longint unsigned r,
                                input int s, output longint unsigned pf,
                                output longint unsigned qf, output longint unsigned rt);
    longint unsigned rr, t, pre, post;
    rr = (p != 0 && r > p) ? p : r;
    if (rr == 0) t = 64'hFFFF_FFFF;
    else t = (p + rr - 1) / rr;
    if (t == 0) t = 1;
    if (s != 3 || t <= 4) begin
      pre = 1;
      post = (t > 4) ? 4 : t;
    end else if (t < 32) begin
      pre = t; post = 1;
    end else begin
      post = (t < 64) ? 2 : (t < 96) ? 3 : 4;
      pre = (t + post - 1) / post;
      if (pre > 32) pre = 32;
    end
    pf = pre - 1;
    qf = post - 1;
    rt = (p / pre) / post;
  endfunction

  task automatic run_op(input logic [31:0] p, input logic [31:0] r, input logic [1:0] s,
                        input string tag);
    longint unsigned epf, eqf, ert;
    @(negedge clk);
    parent = p; target = r; src = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R10 busy after start", busy, 1);
    while (done !== 1'b1) @(negedge clk);
    model(p, r, s, epf, eqf, ert);
    check(busy === 1'b0, "R10 busy low at done", busy, 0);
    check(pre_f == epf[4:0], {tag, " pre field"}, pre_f, epf);
    check(post_f == eqf[1:0], {tag, " post field"}, post_f, eqf);
    check(rate == ert[31:0], {tag, " rate"}, rate, ert);
    @(negedge clk);
    check(done === 1'b0, "R10 done single cycle", done, 0);
    check(rate == ert[31:0], "R10 outputs hold", rate, ert);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int list[8] = '{4, 5, 31, 32, 63, 64, 95, 96};
    longint unsigned epf, eqf, ert;
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; parent = '0; target = '0; src = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 0 && done === 0 && pre_f == 0 && post_f == 0 && rate == 0,
          "reset state", {busy, done}, 0);

    run_op(32'd1000, 32'd5000, 2'd0, "R1 clamp");
    run_op(32'd1000, 32'd300, 2'd0, "R2 ceil");
    run_op(32'd1000, 32'd100, 2'd2, "R3 no split saturate");
    run_op(32'd900, 32'd300, 2'd3, "R3 small ratio src3");
    run_op(32'd1000, 32'd100, 2'd3, "R4 pre only");
    run_op(32'd1000, 32'd20, 2'd3, "R5 band2");
    run_op(32'd7000, 32'd100, 2'd3, "R5 band3");
    run_op(32'd10000, 32'd100, 2'd3, "R5 band4");
    foreach (list[i]) run_op(32'(list[i]), 32'd1, 2'd3, "R5 band edge");
    run_op(32'd1000000, 32'd1, 2'd3, "R8 saturation");
    run_op(32'hFFFF_FFFF, 32'd1, 2'd1, "R8 post saturation");
    run_op(32'd12345, 32'd0, 2'd3, "R9 zero target");
    run_op(32'd0, 32'd5, 2'd3, "R2 zero parent");
    run_op(32'd777, 32'd7, 2'd3, "R6 encoding");
    run_op(32'd5000, 32'd3, 2'd3, "R7 truncation");

    // R10: a second start while busy must not change the result
    @(negedge clk);
    parent = 32'd1000; target = 32'd20; src = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    parent = 32'd999; target = 32'd999; src = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    model(64'd1000, 64'd20, 3, epf, eqf, ert);
    check(rate == ert[31:0] && pre_f == epf[4:0], "R10 start while busy ignored",
          rate, ert);
    @(negedge clk);

    for (int n = 0; n < 220; n++) begin
      logic [31:0] p, r;
      p = $urandom;
      case ($urandom % 4)
        0: r = $urandom;
        1: r = p / ($urandom % 140 + 1);
        2: r = $urandom % 1000;
        default: r = p / ($urandom % 5000 + 1);
      endcase
      run_op(p, r, 2'($urandom % 4), "R6 R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule